// File: doc/BRIEF.md
# Sampled Fault Input Filter

This block removes noise from a group of asynchronous fault inputs before they reach the fault protection logic. Each input passes through a two-flop synchroniser. One prescaler, shared by every input, then issues a sample strobe at a programmable period. A filtered output takes a new level only after enough consecutive samples agree with that level. The outputs are the filtered levels, with high meaning a fault.

One setting pair applies to every channel: a sample period and a sample count. The number of agreeing samples needed is the programmed count plus three. A period of zero turns filtering off, and each output then follows its synchronised input with a fixed delay. When filtering is on, the time to recognise a transition grows with period times the required sample count. The settings are meant to be changed while the block is held in reset.

Top module: `fault_glitch_filter`

## Requirements
- R1: While reset is asserted, every filtered output is 0 (inactive), whatever the inputs are doing.
- R2: With `sample_period` equal to 0, each output equals its input as it stood three clock edges earlier (two synchroniser stages plus one output register).
- R3: A single sample strobe fires once every `sample_period` clocks and serves all channels. Outside a strobe, a filtered output never changes, so inputs that switch together have their outputs switch on the same clock edge.
- R4: With a nonzero period P and count C, let N = C + 3. A level held steady on an input changes the output after at least (N-1)*P+3 and at most N*P+2 clock edges, counted from the first edge that sees the new level. This holds for rising and falling transitions alike.
- R5: An input pulse that lasts no longer than (N-1)*P clocks never changes the output.
- R6: A sample that matches the current output restarts the count of agreeing samples. After a run of disagreeing samples is broken, a new transition again needs the full latency of R4, counted from the point where the level returns.
- R7: Channels are independent. A change on one input leaves the other outputs unchanged.
- R8: `sample_count` is a 3-bit field, so the largest setting (7) requires 10 agreeing samples, and the R4 bounds hold at that setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_period | input | 8 | Clocks between sample strobes; 0 bypasses the filter |
| sample_count | input | 3 | Extra agreeing samples required beyond three |
| fault_raw | input | 4 | Asynchronous fault inputs, high active |
| fault_filt | output | 4 | Filtered fault levels |

## Verification
The bench cannot see the phase of the shared prescaler, so it cannot know which cycle a strobe falls on. It therefore checks transition latency against the two bounds of R4, which cover every phase. A period of 1 removes the uncertainty and gives an exact figure. The hardest case to reach is an agreement count that has built up to one short of its target and is then cleared by a single matching sample. The bench reaches it by holding an input high for exactly (N-1)*P clocks, which allows at most N-1 samples. It then drops the input for exactly P clocks, which guarantees exactly one matching sample. It then measures the full latency again from the return to high.

// File: rtl/ffilt_pkg.sv
package ffilt_pkg;

  // Consecutive agreeing samples needed for a programmed count value.
  function automatic int unsigned samples_needed(input int unsigned cnt_setting);
    return cnt_setting + 3;
  endfunction

  // Width of an agreement counter that can reach the largest target.
  function automatic int unsigned agree_width(input int unsigned cnt_w);
    return $clog2((1 << cnt_w) + 3);
  endfunction

endpackage

// File: rtl/ffilt_sync.sv
module ffilt_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;

endmodule

// File: rtl/ffilt_prescaler.sv
module ffilt_prescaler #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             strobe,
  output logic             bypass
);

  logic [PER_W-1:0] tick_cnt;
  logic             period_zero;
  logic             at_end;

  assign period_zero = (period == '0);
  assign at_end      = (tick_cnt >= (period - PER_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (period_zero || at_end) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + PER_W'(1);
    end
  end

  assign strobe = !period_zero && at_end;
  assign bypass = period_zero;

  // With a steady nonzero period the tick counter stays inside it.
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_zero && $stable(period)) |-> (tick_cnt < period));

endmodule

// File: rtl/ffilt_lane.sv
module ffilt_lane #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             strobe,
  input  logic [CNT_W-1:0] sample_count,
  input  logic             din,
  output logic             dout
);

  localparam int unsigned AGR_W = ffilt_pkg::agree_width(CNT_W);

  logic [AGR_W-1:0] agree;
  logic [AGR_W-1:0] need;
  logic             differs;
  logic             accept;

  assign need    = AGR_W'(ffilt_pkg::samples_needed(32'(sample_count)));
  assign differs = (din != dout);
  assign accept  = strobe && differs && (agree >= (need - AGR_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      agree <= '0;
    end else if (bypass) begin
      dout  <= din;
      agree <= '0;
    end else if (strobe) begin
      if (!differs) begin
        agree <= '0;
      end else if (accept) begin
        dout  <= din;
        agree <= '0;
      end else begin
        agree <= agree + AGR_W'(1);
      end
    end
  end

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !strobe) |=> $stable(dout));

  assert_no_early_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && strobe && (agree < (need - AGR_W'(1)))) |=> $stable(dout));

  assert_restart_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && strobe && !differs) |=> (agree == '0));

endmodule

// File: rtl/fault_glitch_filter.sv
module fault_glitch_filter #(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  sample_period,
  input  logic [CNT_W-1:0]  sample_count,
  input  logic [NUM_IN-1:0] fault_raw,
  output logic [NUM_IN-1:0] fault_filt
);

  logic [NUM_IN-1:0] fault_sync;
  logic              sample_strobe;
  logic              filt_bypass;

  ffilt_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (fault_raw),
    .sync_out (fault_sync)
  );

  ffilt_prescaler #(.PER_W(PER_W)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (sample_period),
    .strobe (sample_strobe),
    .bypass (filt_bypass)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    ffilt_lane #(.CNT_W(CNT_W)) u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .bypass       (filt_bypass),
      .strobe       (sample_strobe),
      .sample_count (sample_count),
      .din          (fault_sync[g]),
      .dout         (fault_filt[g])
    );
  end

  // Edges since reset release, saturating, for the bypass delay check.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_inactive_R1: assert property (@(posedge clk)
    !rst_n |=> (fault_filt == '0));

  assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd3) && $past(sample_period == '0)) |-> (fault_filt == $past(fault_raw, 3)));

endmodule

// File: tb/fault_glitch_filter_bench.sv
module fault_glitch_filter_bench;

  localparam int NUM_IN = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       sample_period = '0;
  logic [2:0]       sample_count = '0;
  logic [NUM_IN-1:0] fault_raw = '0;
  logic [NUM_IN-1:0] fault_filt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fault_glitch_filter u_fault_glitch_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_period (sample_period),
    .sample_count  (sample_count),
    .fault_raw     (fault_raw),
    .fault_filt    (fault_filt)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset(input int per, input int cnt);
    @(negedge clk);
    rst_n = 1'b0;
    sample_period = 8'(per);
    sample_count = 3'(cnt);
    fault_raw = '1;
    repeat (3) @(negedge clk);
    check(fault_filt == '0, "R1 outputs inactive in reset", fault_filt, 0);
    fault_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Counts clock edges until the lane output reaches val (0 if it never does).
  task automatic edges_until(input int lane, input bit val, input int limit, output int k);
    k = 0;
    while (k < limit && fault_filt[lane] != val) begin
      @(negedge clk);
      k++;
    end
    if (fault_filt[lane] != val) k = 0;
  endtask

  task automatic t_reset();
    do_reset(1, 0);
    check(fault_filt == '0, "R1 outputs inactive after reset", fault_filt, 0);
  endtask

  task automatic t_bypass();
    do_reset(0, 2);
    fault_raw = 4'b1010;
    repeat (2) @(negedge clk);
    check(fault_filt == 4'b0000, "R2 bypass not yet after two edges", fault_filt, 0);
    @(negedge clk);
    check(fault_filt == 4'b1010, "R2 bypass after three edges", fault_filt, 4'b1010);
    fault_raw = 4'b0101;
    repeat (3) @(negedge clk);
    check(fault_filt == 4'b0101, "R2 bypass second pattern", fault_filt, 4'b0101);
  endtask

  task automatic t_latency(input int per, input int cnt, input string req);
    int n, lo, hi, k;
    n = cnt + 3;
    lo = (n - 1) * per + 3;
    hi = n * per + 2;
    do_reset(per, cnt);
    @(negedge clk);
    fault_raw[0] = 1'b1;
    edges_until(0, 1'b1, hi + 20, k);
    check(k >= lo && k <= hi, {req, " rising latency"}, k, lo);
    repeat (3) @(negedge clk);
    fault_raw[0] = 1'b0;
    edges_until(0, 1'b0, hi + 20, k);
    check(k >= lo && k <= hi, {req, " falling latency"}, k, lo);
  endtask

  task automatic t_glitch();
    int n, len;
    bit rose;
    n = 1 + 3;
    len = (n - 1) * 3;
    do_reset(3, 1);
    rose = 1'b0;
    fault_raw[2] = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (fault_filt[2]) rose = 1'b1;
    end
    fault_raw[2] = 1'b0;
    for (int i = 0; i < n * 3 + 6; i++) begin
      @(negedge clk);
      if (fault_filt[2]) rose = 1'b1;
    end
    check(!rose, "R5 short pulse ignored", rose, 0);
  endtask

  task automatic t_restart();
    int n, per, k;
    bit rose;
    per = 2;
    n = 1 + 3;
    do_reset(per, 1);
    rose = 1'b0;
    fault_raw[1] = 1'b1;
    for (int i = 0; i < (n - 1) * per; i++) begin
      @(negedge clk);
      if (fault_filt[1]) rose = 1'b1;
    end
    fault_raw[1] = 1'b0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      if (fault_filt[1]) rose = 1'b1;
    end
    check(!rose, "R6 no transition before dip", rose, 0);
    fault_raw[1] = 1'b1;
    edges_until(1, 1'b1, n * per + 20, k);
    check(k >= (n - 1) * per + 3 && k <= n * per + 2, "R6 full latency after restart", k, (n - 1) * per + 3);
  endtask

  task automatic t_independent();
    int k;
    bit others;
    do_reset(2, 0);
    others = 1'b0;
    fault_raw[3] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (fault_filt[2:0] != 3'b000) others = 1'b1;
    end
    check(!others, "R7 other lanes unchanged", fault_filt, 4'b1000);
    check(fault_filt[3] == 1'b1, "R7 driven lane changed", fault_filt[3], 1);
    // All lanes switched together must change on the same edge.
    fault_raw = 4'b0111;
    k = 0;
    while (k < 30 && fault_filt == 4'b1000) begin
      @(negedge clk);
      k++;
    end
    check(fault_filt == 4'b0111, "R3 shared strobe aligns lanes", fault_filt, 4'b0111);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_latency(1, 0, "R4 period1 count0");
    t_latency(4, 2, "R4 period4 count2");
    t_latency(2, 7, "R8 max count");
    t_glitch();
    t_restart();
    t_independent();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule